// File: doc/BRIEF.md
# Scatter-Gather Region Table DMA Engine

This block moves data between a device-side byte stream and system memory by following a table of 8-byte region entries in memory. Software points the engine at the table and pulses an arm input; the engine reads the first entry, marks itself active and waits. Each later transfer request carries a byte length and a direction. The engine works through the current region and reads further entries as it needs them. If a request ends partway through a region, the engine keeps the position, so the next request picks up from the following byte.

A request can end in one of four ways, and each is reported with a one-cycle done pulse and a completion code. The request can end inside a region. It can end exactly at the end of a region that is not the last one. It can end exactly at the end of the last region. Or it can run past the last region. A request made while the engine is not active returns a separate "not active" code and touches nothing. Data moves one 32-bit memory beat at a time. Byte enables follow the address offset and the number of bytes left.

Top module: `prd_dma_engine`

## Requirements
- R1: A table entry is two little-endian 32-bit words read at the entry pointer and the pointer plus 4. The first word is the region base, with bit 0 forced to 0. In the second word, bit 31 set marks the last region. The table pointer ignores its low two bits and advances by 8 after each entry is read.
- R2: The region byte count is bits 15:0 of the second word with bit 0 cleared. A result of zero means 65536 bytes.
- R3: An arm pulse in idle sets active_o and fetches the first entry. busy_o stays high from acceptance until the done pulse or the end of the fetch. Requests and arm pulses that arrive while busy_o is high are ignored.
- R4: A request while active_o is low produces done_o with code 2 and no memory access.
- R5: A request shorter than what remains of the region moves exactly its length and completes with code 1 and error_o cleared. The next request resumes at the following byte.
- R6: A request that ends exactly at the end of a non-last region completes with code 1 and error_o cleared, and no entry is fetched. The next entry is fetched by the next request.
- R7: A request that still has bytes left after the last region is used up sets error_o and completes with code 0. active_o stays set.
- R8: A request that ends exactly at the end of the last region completes with code 1 and clears active_o and error_o.
- R9: When a non-last region runs out and bytes remain, the next entry is fetched and the transfer continues in the same request.
- R10: Each data beat is one word-aligned access carrying at most 4 bytes and never crossing a word boundary. Byte-enable bit i selects address offset i. The enabled lanes are contiguous and start at the current address offset.
- R11: Once raised, mem_req_o stays high with a stable address, write flag and byte enables until mem_ack_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Pulse: load table pointer and fetch first entry |
| tbl_ptr_i | input | AW | Table base byte address |
| req_i | input | 1 | Pulse: start a transfer request |
| req_len_i | input | LEN_W | Request length in bytes |
| req_to_mem_i | input | 1 | 1: device stream to memory; 0: memory to device stream |
| busy_o | output | 1 | Engine is handling an arm or a request |
| done_o | output | 1 | One-cycle completion pulse |
| code_o | output | 2 | Completion code: 0 error, 1 done, 2 not active |
| active_o | output | 1 | Engine armed with a valid region |
| error_o | output | 1 | Last request overran the table |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | AW | Word-aligned memory address |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access accepted this cycle; read data valid |
| mem_rdata_i | input | 32 | Read data |
| dev_wdata_i | input | 32 | Device data, lane-aligned to the memory address |
| dev_pop_o | output | 1 | Device word consumed |
| dev_rdata_o | output | 32 | Data for the device, lane-aligned |
| dev_push_o | output | 1 | dev_rdata_o valid |

## Verification
The assertions are evaluated on every cycle. They cover the memory handshake hold, non-empty byte enables, the immediate "not active" reply, and error_o rising only together with a code-0 done pulse. They also check that active_o falls only together with a code-1 done pulse. The bench scenarios cover the rest. Those behaviours include the table layout and pointer stepping, count masking and the 65536-byte case, and resuming across requests. The bench also shows that no entry is fetched at a non-last boundary, that a fetch happens within a request, and the lane pattern at unaligned region edges. Each of these depends on the order of memory contents and fetches.

// File: rtl/prd_pkg.sv
package prd_pkg;
    localparam int CNT_W = 17;

    localparam logic [1:0] CODE_FAIL = 2'd0;
    localparam logic [1:0] CODE_OK   = 2'd1;
    localparam logic [1:0] CODE_OFF  = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_FET0 = 3'd1,
        S_FET1 = 3'd2,
        S_CHK  = 3'd3,
        S_BEAT = 3'd4,
        S_DONE = 3'd5
    } prd_state_e;
endpackage

// File: rtl/prd_entry_decode.sv
module prd_entry_decode
    import prd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [31:0]      base_word_i,
    input  logic [15:0]      len_bits_i,
    input  logic             last_bit_i,
    output logic [AW-1:0]    base_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);
    logic [15:0] len_even;

    always_comb begin
        len_even = len_bits_i & 16'hFFFE;
        base_o   = AW'(base_word_i & 32'hFFFF_FFFE);
        last_o   = last_bit_i;
        if (len_even == 16'd0) begin
            cnt_o = CNT_W'(17'h1_0000);
        end else begin
            cnt_o = CNT_W'(len_even);
        end
    end
endmodule

// File: rtl/prd_beat_calc.sv
module prd_beat_calc
    import prd_pkg::*;
#(
    parameter int LEN_W = 17
) (
    input  logic [1:0]       off_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [LEN_W-1:0] rem_i,
    output logic [2:0]       n_o,
    output logic [3:0]       be_o
);
    logic [2:0] room;
    logic [2:0] lim;
    logic [3:0] mask;

    always_comb begin
        room = 3'd4 - {1'b0, off_i};
        lim  = room;
        if (cnt_i < CNT_W'(room)) begin
            lim = cnt_i[2:0];
        end
        if (rem_i < LEN_W'(lim)) begin
            lim = rem_i[2:0];
        end
        mask = 4'((5'd1 << lim) - 5'd1);
        be_o = mask << off_i;
        n_o  = lim;
    end
endmodule

// File: rtl/prd_dma_engine.sv
module prd_dma_engine
    import prd_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [AW-1:0]    tbl_ptr_i,
    input  logic             req_i,
    input  logic [LEN_W-1:0] req_len_i,
    input  logic             req_to_mem_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [1:0]       code_o,
    output logic             active_o,
    output logic             error_o,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [3:0]       mem_be_o,
    output logic [31:0]      mem_wdata_o,
    input  logic             mem_ack_i,
    input  logic [31:0]      mem_rdata_i,
    input  logic [31:0]      dev_wdata_i,
    output logic             dev_pop_o,
    output logic [31:0]      dev_rdata_o,
    output logic             dev_push_o
);
    localparam logic [AW-1:0] ENTRY_STEP = AW'(8);
    localparam logic [AW-1:0] WORD_STEP  = AW'(4);
    localparam logic [AW-1:0] WORD_MASK  = ~AW'(3);

    typedef struct packed {
        prd_state_e       st;
        logic [AW-1:0]    ptr;
        logic [AW-1:0]    addr;
        logic [CNT_W-1:0] cnt;
        logic             last;
        logic [LEN_W-1:0] rem;
        logic             to_mem;
        logic             act;
        logic             err;
        logic [1:0]       code;
        logic             arming;
        logic [31:0]      w0;
    } eng_t;

    eng_t q, d;

    logic [AW-1:0]    dec_base;
    logic [CNT_W-1:0] dec_cnt;
    logic             dec_last;
    logic [2:0]       beat_n;
    logic [3:0]       beat_be;

    prd_entry_decode #(.AW(AW)) u_dec (
        .base_word_i (q.w0),
        .len_bits_i  (mem_rdata_i[15:0]),
        .last_bit_i  (mem_rdata_i[31]),
        .base_o      (dec_base),
        .cnt_o       (dec_cnt),
        .last_o      (dec_last)
    );

    prd_beat_calc #(.LEN_W(LEN_W)) u_beat (
        .off_i (q.addr[1:0]),
        .cnt_i (q.cnt),
        .rem_i (q.rem),
        .n_o   (beat_n),
        .be_o  (beat_be)
    );

    always_comb begin
        d = q;
        case (q.st)
            S_IDLE: begin
                if (arm_i) begin
                    d.ptr    = tbl_ptr_i & WORD_MASK;
                    d.act    = 1'b1;
                    d.arming = 1'b1;
                    d.st     = S_FET0;
                end else if (req_i) begin
                    if (!q.act) begin
                        d.code = CODE_OFF;
                        d.st   = S_DONE;
                    end else begin
                        d.rem    = req_len_i;
                        d.to_mem = req_to_mem_i;
                        d.arming = 1'b0;
                        d.st     = S_CHK;
                    end
                end
            end
            S_FET0: begin
                if (mem_ack_i) begin
                    d.w0 = mem_rdata_i;
                    d.st = S_FET1;
                end
            end
            S_FET1: begin
                if (mem_ack_i) begin
                    d.addr = dec_base;
                    d.cnt  = dec_cnt;
                    d.last = dec_last;
                    d.ptr  = q.ptr + ENTRY_STEP;
                    d.st   = q.arming ? S_IDLE : S_CHK;
                end
            end
            S_CHK: begin
                if (q.cnt == '0) begin
                    if (q.rem == '0) begin
                        d.err  = 1'b0;
                        d.code = CODE_OK;
                        if (q.last) begin
                            d.act = 1'b0;
                        end
                        d.st = S_DONE;
                    end else if (q.last) begin
                        d.err  = 1'b1;
                        d.code = CODE_FAIL;
                        d.st   = S_DONE;
                    end else begin
                        d.st = S_FET0;
                    end
                end else if (q.rem == '0) begin
                    d.err  = 1'b0;
                    d.code = CODE_OK;
                    d.st   = S_DONE;
                end else begin
                    d.st = S_BEAT;
                end
            end
            S_BEAT: begin
                if (mem_ack_i) begin
                    d.addr = q.addr + AW'(beat_n);
                    d.cnt  = q.cnt - CNT_W'(beat_n);
                    d.rem  = q.rem - LEN_W'(beat_n);
                    d.st   = S_CHK;
                end
            end
            S_DONE:  d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        busy_o      = (q.st != S_IDLE);
        done_o      = (q.st == S_DONE);
        code_o      = q.code;
        active_o    = q.act;
        error_o     = q.err;
        mem_req_o   = (q.st == S_FET0) || (q.st == S_FET1) || (q.st == S_BEAT);
        mem_we_o    = (q.st == S_BEAT) && q.to_mem;
        mem_wdata_o = dev_wdata_i;
        dev_rdata_o = mem_rdata_i;
        dev_pop_o   = (q.st == S_BEAT) && q.to_mem && mem_ack_i;
        dev_push_o  = (q.st == S_BEAT) && !q.to_mem && mem_ack_i;
        case (q.st)
            S_FET0:  mem_addr_o = q.ptr;
            S_FET1:  mem_addr_o = q.ptr + WORD_STEP;
            default: mem_addr_o = q.addr & WORD_MASK;
        endcase
        mem_be_o = (q.st == S_BEAT) ? beat_be : 4'hF;
    end

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_we_o) && $stable(mem_be_o)));

    p_be_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_be_o != 4'h0));

    p_off_reply_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !arm_i && !busy_o && !active_o) |=> (done_o && code_o == CODE_OFF && !mem_req_o));

    p_err_on_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error_o) |-> (done_o && code_o == CODE_FAIL));

    p_act_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_o) |-> (done_o && code_o == CODE_OK && !error_o));
endmodule

// File: tb/tb_prd_dma_engine.sv
`timescale 1ns/1ps
module tb_prd_dma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic [31:0] tbl = '0;
    logic        req = 1'b0;
    logic [16:0] len = '0;
    logic        tomem = 1'b0;
    logic        ack = 1'b0;
    logic [31:0] rdata, wdata_dev;
    logic        busy, done, act, err, mreq, mwe, pop, push;
    logic [1:0]  code;
    logic [31:0] maddr, mwdata, drdata;
    logic [3:0]  mbe;

    logic [7:0]  mem [0:1023];
    logic        pk_en = 1'b0;
    logic [9:0]  pk_a = '0;
    logic [7:0]  pk_d = '0;
    logic [1:0]  tick = '0;

    int checks = 0, errors = 0;
    int n_done = 0, n_fetch = 0, n_acc = 0, n_wr = 0, n_rdb = 0, n_rdbad = 0;
    logic [31:0] fa0 = '0, fa1 = '0;
    logic [3:0]  wlog [0:15];

    always #10 clk = ~clk;

    function automatic logic [7:0] pat(input logic [9:0] a);
        return a[7:0] ^ 8'hA5;
    endfunction

    wire [9:0] wbase = {maddr[9:2], 2'b00};
    assign rdata = {mem[wbase + 10'd3], mem[wbase + 10'd2], mem[wbase + 10'd1], mem[wbase]};
    assign wdata_dev = {pat(wbase + 10'd3), pat(wbase + 10'd2), pat(wbase + 10'd1), pat(wbase)};

    prd_dma_engine dut (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .tbl_ptr_i(tbl), .req_i(req),
        .req_len_i(len), .req_to_mem_i(tomem), .busy_o(busy), .done_o(done),
        .code_o(code), .active_o(act), .error_o(err), .mem_req_o(mreq),
        .mem_we_o(mwe), .mem_addr_o(maddr), .mem_be_o(mbe), .mem_wdata_o(mwdata),
        .mem_ack_i(ack), .mem_rdata_i(rdata), .dev_wdata_i(wdata_dev),
        .dev_pop_o(pop), .dev_rdata_o(drdata), .dev_push_o(push)
    );

    always @(negedge clk) begin
        tick <= tick + 2'd1;
        ack  <= mreq && (tick != 2'd0);
    end

    always @(posedge clk) begin
        if (pk_en) begin
            mem[pk_a] <= pk_d;
        end else if (mreq && ack && mwe) begin
            for (int i = 0; i < 4; i++)
                if (mbe[i]) mem[wbase + 10'(i)] <= mwdata[8*i +: 8];
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (done) n_done++;
            if (mreq && ack) begin
                n_acc++;
                if (!mwe && !push) begin
                    n_fetch++;
                    fa0 = fa1;
                    fa1 = maddr;
                end
                if (mwe) begin
                    wlog[n_wr % 16] = mbe;
                    n_wr++;
                end
                if (push) begin
                    for (int i = 0; i < 4; i++)
                        if (mbe[i]) begin
                            n_rdb++;
                            if (drdata[8*i +: 8] != mem[wbase + 10'(i)]) n_rdbad++;
                        end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint a, input longint e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
        end
    endtask

    task automatic poke(input logic [9:0] a, input logic [7:0] v);
        @(negedge clk);
        pk_en = 1'b1; pk_a = a; pk_d = v;
        @(negedge clk);
        pk_en = 1'b0;
    endtask

    task automatic poke32(input logic [9:0] a, input logic [31:0] v);
        for (int i = 0; i < 4; i++) poke(a + 10'(i), v[8*i +: 8]);
    endtask

    task automatic do_arm(input logic [31:0] p);
        @(negedge clk);
        arm = 1'b1; tbl = p;
        @(negedge clk);
        arm = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic do_req(input int l, input bit dir, input bit pester, output logic [1:0] c);
        int k;
        @(negedge clk);
        req = 1'b1; len = 17'(l); tomem = dir;
        k = 0;
        forever begin
            @(negedge clk);
            req = 1'b0;
            if (pester && k == 1 && busy) begin
                req = 1'b1; len = 17'd100;
            end
            k++;
            if (done) break;
        end
        c = code;
        @(negedge clk);
        req = 1'b0;
    endtask

    function automatic bit span_ok(input int lo, input int hi, input bit written);
        for (int a = lo; a <= hi; a++)
            if (mem[a] != (written ? pat(10'(a)) : 8'h00)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic t_reset;
        chk(!busy, "R3 reset busy", busy, 0);
        chk(!act, "R3 reset active", act, 0);
        chk(!err, "R7 reset error", err, 0);
        chk(!done && !mreq, "R3 reset idle outputs", {done, mreq}, 0);
    endtask

    task automatic t_off;
        logic [1:0] c; int a0;
        a0 = n_acc;
        do_req(4, 1'b1, 1'b0, c);
        chk(c == 2'd2, "R4 not-active code", c, 2);
        chk(n_acc == a0, "R4 no memory access", n_acc - a0, 0);
    endtask

    task automatic t_walk;
        logic [1:0] c; int f0, d0, w0;
        poke32(10'h100, 32'h0000_0201);
        poke32(10'h104, 32'h0000_0007);
        poke32(10'h108, 32'h0000_0212);
        poke32(10'h10C, 32'h8000_000A);
        f0 = n_fetch;
        do_arm(32'h0000_0103);
        chk(n_fetch - f0 == 2, "R1 arm reads two words", n_fetch - f0, 2);
        chk(fa0 == 32'h100 && fa1 == 32'h104, "R1 entry word addresses", {fa0, fa1}, 64'h100_0000_0104);
        chk(act, "R3 arm sets active", act, 1);

        do_req(4, 1'b1, 1'b0, c);
        chk(c == 2'd1 && !err, "R5 partial code", c, 1);
        chk(span_ok(16'h200, 16'h203, 1) && span_ok(16'h204, 16'h204, 0), "R5 partial bytes", mem[10'h204], 0);

        f0 = n_fetch; d0 = n_done;
        do_req(2, 1'b1, 1'b1, c);
        chk(c == 2'd1 && act, "R6 boundary code", c, 1);
        chk(span_ok(16'h204, 16'h205, 1) && span_ok(16'h206, 16'h211, 0), "R5 resume bytes", mem[10'h204], pat(10'h204));
        chk(n_fetch == f0, "R6 no fetch at boundary", n_fetch - f0, 0);
        repeat (8) @(negedge clk);
        chk(n_done - d0 == 1 && !busy, "R3 busy request ignored", n_done - d0, 1);

        f0 = n_fetch; w0 = n_wr;
        do_req(8, 1'b1, 1'b0, c);
        chk(n_fetch - f0 == 2 && fa0 == 32'h108, "R9 fetch next entry", fa0, 32'h108);
        chk(wlog[w0 % 16] == 4'b1100, "R10 leading lanes", wlog[w0 % 16], 4'b1100);
        chk(wlog[(w0 + 2) % 16] == 4'b0011 && n_wr - w0 == 3, "R10 trailing lanes", wlog[(w0 + 2) % 16], 4'b0011);
        chk(c == 2'd1 && span_ok(16'h212, 16'h219, 1) && span_ok(16'h211, 16'h211, 0)
            && span_ok(16'h21A, 16'h21A, 0), "R9 continued bytes", c, 1);

        do_req(2, 1'b1, 1'b0, c);
        chk(c == 2'd1 && !act && !err, "R8 end of table", {c, act, err}, 4'b0100);
        chk(span_ok(16'h21A, 16'h21B, 1), "R8 last bytes", mem[10'h21B], pat(10'h21B));

        do_req(4, 1'b1, 1'b0, c);
        chk(c == 2'd2, "R4 after end of table", c, 2);
    endtask

    task automatic t_overrun;
        logic [1:0] c; int b0, bad0;
        for (int i = 0; i < 8; i++) poke(10'h300 + 10'(i), 8'(8'h11 * (i + 1)));
        poke32(10'h140, 32'h0000_0300);
        poke32(10'h144, 32'h8000_0004);
        do_arm(32'h0000_0140);
        b0 = n_rdb; bad0 = n_rdbad;
        do_req(8, 1'b0, 1'b0, c);
        chk(c == 2'd0 && err, "R7 overrun code", {c, err}, 3'b001);
        chk(act, "R7 active kept", act, 1);
        chk(n_rdb - b0 == 4 && n_rdbad == bad0, "R7 bytes before overrun", n_rdb - b0, 4);
    endtask

    task automatic t_big;
        logic [1:0] c; int b0;
        poke32(10'h180, 32'h0000_0000);
        poke32(10'h184, 32'h8000_0001);
        do_arm(32'h0000_0180);
        b0 = n_rdb;
        do_req(65534, 1'b0, 1'b0, c);
        chk(c == 2'd1 && act && !err, "R2 zero count is 65536", {c, act}, 3'b011);
        chk(n_rdb - b0 == 65534, "R2 bytes moved", n_rdb - b0, 65534);
        do_req(2, 1'b0, 1'b0, c);
        chk(c == 2'd1 && !act, "R2 exact end at 65536", {c, act}, 3'b010);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        for (int a = 0; a < 1024; a++) begin
            pk_en = 1'b1; pk_a = 10'(a); pk_d = 8'h00;
            @(negedge clk);
        end
        pk_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_off;
        t_walk;
        t_overrun;
        t_big;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule